// File: doc/BRIEF.md
# PC-indexed cache bypass predictor

This block models the tag side of a set-associative first-level data cache and decides, per miss, whether a line is worth allocating. A table of small saturating counters is indexed by a 7-bit hash of the instruction address (PC) of the request. A counter at or above a threshold marks its instruction as one whose fetched lines tend to die without being touched again, so a miss from that instruction is flagged as a bypass. The set is then left untouched, with no fill and no eviction.

Every line remembers the hash of the last instruction that touched it. An eviction of a valid line raises the counter of that last toucher, because that access ended the line's useful life. A hit lowers the counter of the previous toucher, because that guess of death was wrong, and then records the current instruction as the new last toucher. One request is taken per cycle through a valid/ready pair. Its hit, bypass and eviction results, with the evicted line's address, appear on the response outputs the following cycle. No data is stored.

Top module: `bp_cache_bypass`

## Requirements
- R1: After reset every line is invalid, every counter is 0, `rsp_valid` is low and `req_ready` is high from the first cycle after reset is released.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` high) produces `rsp_valid` high for exactly the following cycle. No response appears in a cycle after an edge without an accepted request.
- R3: The set index is `req_addr[10:6]` and the tag is `req_addr[31:11]` (default 32 sets of 64-byte lines). A request whose tag matches a valid line of its set reports `rsp_hit` with no bypass and no eviction.
- R4: A miss whose counter is below the threshold fills an invalid way of the set if one exists, reporting neither bypass nor eviction.
- R5: A miss in a full set with its counter below the threshold replaces the least recently used way. It raises `rsp_evict`, gives the victim's line-aligned address on `rsp_evict_addr`, and increments the counter indexed by the victim's stored hash.
- R6: A miss whose counter is at or above the threshold (default 8, so exactly 8 bypasses) reports `rsp_bypass`, allocates nothing, evicts nothing and changes no LRU order.
- R7: A hit decrements the counter indexed by the line's stored hash, then stores the current request's hash in the line and makes that line most recently used.
- R8: Counters are 4 bits and saturate: a decrement at 0 leaves 0 and an increment at 15 leaves 15.
- R9: The hash is the XOR of the 7-bit slices of `req_pc[31:2]`, zero-extended at the top. PC bits [1:0] do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_pc | input | 32 | Instruction address of the access |
| req_addr | input | 32 | Byte address of the access |
| rsp_valid | output | 1 | Result of the request accepted at the previous edge |
| rsp_hit | output | 1 | The request hit a valid line |
| rsp_bypass | output | 1 | The miss was predicted dead and not allocated |
| rsp_evict | output | 1 | A valid line was replaced |
| rsp_evict_addr | output | 32 | Line-aligned address of the replaced line |

## Verification
The hardest state to reach from the ports is a counter pinned at its upper limit. Once an instruction's counter passes the threshold, that instruction can no longer allocate lines, so it can no longer train itself upward. The stimulus gets around this by filling one set with lines from a second instruction and then hitting every line with the first. This hands ownership of the lines to the first instruction without allocation. A third instruction then evicts all of them, driving the counter past 15. A later bypass shows that it saturated and did not wrap to a small value. The lower limit is reached by hitting a line whose owner's counter is already 0. A later miss from that owner must still allocate.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // Outcome of one accepted request
   typedef enum logic [1:0] {
      BP_FILL   = 2'd0,
      BP_HIT    = 2'd1,
      BP_BYPASS = 2'd2,
      BP_EVICT  = 2'd3
   } bp_out_e;

endpackage

// File: rtl/bp_pc_hash.sv
// Folds the instruction address, above its alignment bits, into HW bits by XOR.
module bp_pc_hash #(
   parameter int PC_W  = 32,
   parameter int ALIGN = 2,
   parameter int HW    = 7
) (
   input  logic [PC_W-1:0] pc,
   output logic [HW-1:0]   hash
);
   localparam int USE_W = PC_W - ALIGN;
   localparam int NSL   = (USE_W + HW - 1) / HW;
   localparam int PAD_W = NSL * HW;

   logic [PAD_W-1:0] padded;
   logic [HW-1:0]    acc [NSL+1];

   assign padded = PAD_W'(pc[PC_W-1:ALIGN]);
   assign acc[0] = '0;

   for (genvar g = 0; g < NSL; g++) begin : g_slice
      assign acc[g+1] = acc[g] ^ padded[g*HW +: HW];
   end

   assign hash = acc[NSL];

   if (ALIGN > 0) begin : g_drop_low
      logic unused_low;
      assign unused_low = ^pc[ALIGN-1:0];
   end
endmodule

// File: rtl/bp_ctr_table.sv
// Saturating counter table: one read port, one decrement and one increment per cycle.
module bp_ctr_table #(
   parameter int ENTRIES = 128,
   parameter int CW      = 4,
   parameter int THRESH  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(ENTRIES)-1:0] rd_idx,
   output logic                       rd_over,
   input  logic                       dec_en,
   input  logic [$clog2(ENTRIES)-1:0] dec_idx,
   input  logic                       inc_en,
   input  logic [$clog2(ENTRIES)-1:0] inc_idx
);
   localparam int          IW   = $clog2(ENTRIES);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] ctr_view [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam logic [IW-1:0] MY = IW'(i);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] after_dec;
      logic [CW-1:0] after_inc;

      // Decrement first, then increment, so a double hit on one entry loses neither
      always_comb begin
         after_dec = cnt_q;
         if (dec_en && dec_idx == MY && cnt_q != '0) after_dec = cnt_q - 1'b1;
         after_inc = after_dec;
         if (inc_en && inc_idx == MY && after_dec != CMAX) after_inc = after_dec + 1'b1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= after_inc;
      end

      assign ctr_view[i] = cnt_q;
   end

   assign rd_over = (ctr_view[rd_idx] >= CW'(THRESH));
endmodule

// File: rtl/bp_tag_array.sv
// Tags, valid bits, last-accessor hashes and age-based LRU for every set.
module bp_tag_array #(
   parameter int SETS  = 32,
   parameter int WAYS  = 8,
   parameter int TAG_W = 21,
   parameter int HW    = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(SETS)-1:0]  lk_set,
   input  logic [TAG_W-1:0]         lk_tag,
   output logic                     hit,
   output logic [$clog2(WAYS)-1:0]  hit_way,
   output logic [HW-1:0]            hit_hpc,
   output logic [$clog2(WAYS)-1:0]  vic_way,
   output logic                     vic_valid,
   output logic [TAG_W-1:0]         vic_tag,
   output logic [HW-1:0]            vic_hpc,
   input  logic                     upd_en,
   input  logic                     upd_fill,
   input  logic [$clog2(WAYS)-1:0]  upd_way,
   input  logic [HW-1:0]            upd_hpc
);
   localparam int             WAY_W  = $clog2(WAYS);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic [WAYS-1:0]  valid_q [SETS];
   logic [WAY_W-1:0] age_q   [SETS][WAYS];
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [HW-1:0]    hpc_q   [SETS][WAYS];
   logic [WAYS-1:0]  match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
   end

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   // Lowest invalid way first, otherwise the way with the greatest age
   always_comb begin
      logic found;
      found   = 1'b0;
      vic_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !valid_q[lk_set][w]) begin
            vic_way = WAY_W'(w);
            found   = 1'b1;
         end
      end
      if (!found) begin
         for (int w = 0; w < WAYS; w++) begin
            if (age_q[lk_set][w] == OLDEST) vic_way = WAY_W'(w);
         end
      end
   end

   assign hit_hpc   = hpc_q[lk_set][hit_way];
   assign vic_valid = valid_q[lk_set][vic_way];
   assign vic_tag   = tag_q[lk_set][vic_way];
   assign vic_hpc   = hpc_q[lk_set][vic_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else if (upd_en) begin
         if (upd_fill) valid_q[lk_set][upd_way] <= 1'b1;
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == upd_way)
               age_q[lk_set][w] <= '0;
            else if (age_q[lk_set][w] < age_q[lk_set][upd_way])
               age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (upd_en) begin
         hpc_q[lk_set][upd_way] <= upd_hpc;
         if (upd_fill) tag_q[lk_set][upd_way] <= lk_tag;
      end
   end
endmodule

// File: rtl/bp_cache_bypass.sv
module bp_cache_bypass #(
   parameter int PC_W        = 32,
   parameter int ADDR_W      = 32,
   parameter int SETS        = 32,
   parameter int LINE_B      = 64,
   parameter int WAYS        = 8,
   parameter int TBL_ENTRIES = 128,
   parameter int CTR_W       = 4,
   parameter int THRESH      = 8,
   parameter int PC_ALIGN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PC_W-1:0]   req_pc,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_bypass,
   output logic              rsp_evict,
   output logic [ADDR_W-1:0] rsp_evict_addr
);
   import bp_pkg::*;

   localparam int OFF_W = $clog2(LINE_B);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
   localparam int HW    = $clog2(TBL_ENTRIES);
   localparam int WAY_W = $clog2(WAYS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_B < 2 || (LINE_B & (LINE_B - 1)) != 0) begin : g_bad_line
      $error("LINE_B must be a power of two");
   end
   if ((TBL_ENTRIES & (TBL_ENTRIES - 1)) != 0 || TBL_ENTRIES < 2) begin : g_bad_tbl
      $error("TBL_ENTRIES must be a power of two");
   end
   if (THRESH < 1 || THRESH > (1 << CTR_W) - 1) begin : g_bad_thr
      $error("THRESH must lie within the counter range");
   end
   if (TAG_W < 1 || PC_ALIGN >= PC_W) begin : g_bad_split
      $error("address or PC split leaves no bits");
   end

   logic                 accept;
   logic [IDX_W-1:0]     set_idx;
   logic [TAG_W-1:0]     tag_in;
   logic [HW-1:0]        req_hash;
   logic                 over;
   logic                 hit;
   logic [WAY_W-1:0]     hit_way;
   logic [HW-1:0]        hit_hpc;
   logic [WAY_W-1:0]     vic_way;
   logic                 vic_valid;
   logic [TAG_W-1:0]     vic_tag;
   logic [HW-1:0]        vic_hpc;
   bp_out_e              outcome;
   logic                 unused_off;
   logic                 ready_q;

   assign set_idx    = req_addr[OFF_W +: IDX_W];
   assign tag_in     = req_addr[ADDR_W-1 -: TAG_W];
   assign unused_off = ^req_addr[OFF_W-1:0];
   assign accept     = req_valid && ready_q;
   assign req_ready  = ready_q;

   bp_pc_hash #(.PC_W(PC_W), .ALIGN(PC_ALIGN), .HW(HW)) u_hash (
      .pc   (req_pc),
      .hash (req_hash)
   );

   bp_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .HW(HW)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_set    (set_idx),
      .lk_tag    (tag_in),
      .hit       (hit),
      .hit_way   (hit_way),
      .hit_hpc   (hit_hpc),
      .vic_way   (vic_way),
      .vic_valid (vic_valid),
      .vic_tag   (vic_tag),
      .vic_hpc   (vic_hpc),
      .upd_en    (accept && outcome != BP_BYPASS),
      .upd_fill  (!hit),
      .upd_way   (hit ? hit_way : vic_way),
      .upd_hpc   (req_hash)
   );

   always_comb begin
      if (hit)            outcome = BP_HIT;
      else if (over)      outcome = BP_BYPASS;
      else if (vic_valid) outcome = BP_EVICT;
      else                outcome = BP_FILL;
   end

   // A hit trains the previous toucher down; an eviction trains the victim's toucher up
   bp_ctr_table #(.ENTRIES(TBL_ENTRIES), .CW(CTR_W), .THRESH(THRESH)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (req_hash),
      .rd_over (over),
      .dec_en  (accept && outcome == BP_HIT),
      .dec_idx (hit_hpc),
      .inc_en  (accept && outcome == BP_EVICT),
      .inc_idx (vic_hpc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q        <= 1'b0;
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_bypass     <= 1'b0;
         rsp_evict      <= 1'b0;
         rsp_evict_addr <= '0;
      end else begin
         ready_q        <= 1'b1;
         rsp_valid      <= accept;
         rsp_hit        <= accept && outcome == BP_HIT;
         rsp_bypass     <= accept && outcome == BP_BYPASS;
         rsp_evict      <= accept && outcome == BP_EVICT;
         rsp_evict_addr <= (accept && outcome == BP_EVICT) ?
                           {vic_tag, set_idx, {OFF_W{1'b0}}} : '0;
      end
   end
endmodule

// File: rtl/bp_cache_bypass_chk.sv
module bp_cache_bypass_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic rsp_valid,
   input logic rsp_hit,
   input logic rsp_bypass,
   input logic rsp_evict
);
   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);

   assert_hit_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_valid && !rsp_bypass && !rsp_evict));

   assert_bypass_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_bypass |-> (rsp_valid && !rsp_evict));

   assert_evict_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_evict |-> (rsp_valid && !rsp_hit));

   assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_hit, rsp_bypass, rsp_evict}));
endmodule

bind bp_cache_bypass bp_cache_bypass_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_bypass (rsp_bypass),
   .rsp_evict  (rsp_evict)
);

// File: tb/tb_bp_cache_bypass.sv
module tb_bp_cache_bypass;
   localparam int CLK_PERIOD = 10;
   localparam int NV         = 53;

   typedef struct packed {
      logic [1:0] pcs;
      logic [4:0] set;
      logic [7:0] tag;
      logic       hit;
      logic       byp;
      logic       ev;
      logic [7:0] evtag;
      logic [3:0] rq;
   } vec_t;

   // PC select: 0 -> 0x100, 1 -> 0x200, 2 -> 0x300, 3 -> 0x103 (same hash as 0x100, R9)
   localparam vec_t VECS [NV] = '{
      // set 0: fill eight invalid ways (R4)
      '{2'd0,5'd0,8'd1,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd0,5'd0,8'd2,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd0,5'd0,8'd3,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd0,5'd0,8'd4,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd0,5'd0,8'd5,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd0,5'd0,8'd6,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd0,5'd0,8'd7,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd0,5'd0,8'd8,1'b0,1'b0,1'b0,8'd0,4'd4},
      // set 0: LRU evictions train counter of 0x100 to 8 (R5)
      '{2'd0,5'd0,8'd9 ,1'b0,1'b0,1'b1,8'd1,4'd5},
      '{2'd0,5'd0,8'd10,1'b0,1'b0,1'b1,8'd2,4'd5},
      '{2'd0,5'd0,8'd11,1'b0,1'b0,1'b1,8'd3,4'd5},
      '{2'd0,5'd0,8'd12,1'b0,1'b0,1'b1,8'd4,4'd5},
      '{2'd0,5'd0,8'd13,1'b0,1'b0,1'b1,8'd5,4'd5},
      '{2'd0,5'd0,8'd14,1'b0,1'b0,1'b1,8'd6,4'd5},
      '{2'd0,5'd0,8'd15,1'b0,1'b0,1'b1,8'd7,4'd5},
      '{2'd0,5'd0,8'd16,1'b0,1'b0,1'b1,8'd8,4'd5},
      // R6 bypass at 8, then the set still holds tag 9 (R3, R7 hit drops counter to 7)
      '{2'd0,5'd0,8'd17,1'b0,1'b1,1'b0,8'd0,4'd6},
      '{2'd0,5'd0,8'd9 ,1'b1,1'b0,1'b0,8'd0,4'd3},
      '{2'd0,5'd0,8'd17,1'b0,1'b0,1'b1,8'd10,4'd7},
      '{2'd1,5'd0,8'd18,1'b0,1'b0,1'b1,8'd11,4'd5},
      '{2'd0,5'd0,8'd19,1'b0,1'b1,1'b0,8'd0,4'd6},
      '{2'd1,5'd0,8'd12,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd0,8'd20,1'b0,1'b1,1'b0,8'd0,4'd6},
      '{2'd1,5'd0,8'd13,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd0,8'd20,1'b0,1'b0,1'b1,8'd14,4'd7},
      // R8 floor: hit on a line owned by 0x200 whose counter is 0, then 0x200 still allocates
      '{2'd1,5'd0,8'd18,1'b1,1'b0,1'b0,8'd0,4'd8},
      '{2'd1,5'd0,8'd21,1'b0,1'b0,1'b1,8'd15,4'd8},
      // set 1: fill with 0x300
      '{2'd2,5'd1,8'd1,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd2,5'd1,8'd2,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd2,5'd1,8'd3,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd2,5'd1,8'd4,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd2,5'd1,8'd5,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd2,5'd1,8'd6,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd2,5'd1,8'd7,1'b0,1'b0,1'b0,8'd0,4'd4},
      '{2'd2,5'd1,8'd8,1'b0,1'b0,1'b0,8'd0,4'd4},
      // set 1: 0x100 takes ownership of every line by hitting (R7)
      '{2'd0,5'd1,8'd1,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd1,8'd2,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd1,8'd3,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd1,8'd4,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd1,8'd5,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd1,8'd6,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd1,8'd7,1'b1,1'b0,1'b0,8'd0,4'd7},
      '{2'd0,5'd1,8'd8,1'b1,1'b0,1'b0,8'd0,4'd7},
      // R9: 0x300 has its own counter, so it allocates while 0x100 climbs past 15
      '{2'd2,5'd1,8'd9 ,1'b0,1'b0,1'b1,8'd1,4'd9},
      '{2'd2,5'd1,8'd10,1'b0,1'b0,1'b1,8'd2,4'd9},
      '{2'd2,5'd1,8'd11,1'b0,1'b0,1'b1,8'd3,4'd9},
      '{2'd2,5'd1,8'd12,1'b0,1'b0,1'b1,8'd4,4'd9},
      '{2'd2,5'd1,8'd13,1'b0,1'b0,1'b1,8'd5,4'd9},
      '{2'd2,5'd1,8'd14,1'b0,1'b0,1'b1,8'd6,4'd9},
      '{2'd2,5'd1,8'd15,1'b0,1'b0,1'b1,8'd7,4'd9},
      '{2'd2,5'd1,8'd16,1'b0,1'b0,1'b1,8'd8,4'd9},
      // R8 ceiling: counter held at 15, so still bypassing; R9 low PC bits ignored
      '{2'd0,5'd2,8'd1,1'b0,1'b1,1'b0,8'd0,4'd8},
      '{2'd3,5'd2,8'd2,1'b0,1'b1,1'b0,8'd0,4'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_pc = '0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic        rsp_bypass;
   logic        rsp_evict;
   logic [31:0] rsp_evict_addr;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bp_cache_bypass dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_pc         (req_pc),
      .req_addr       (req_addr),
      .rsp_valid      (rsp_valid),
      .rsp_hit        (rsp_hit),
      .rsp_bypass     (rsp_bypass),
      .rsp_evict      (rsp_evict),
      .rsp_evict_addr (rsp_evict_addr)
   );

   function automatic logic [31:0] pc_of(input logic [1:0] s);
      case (s)
         2'd0:    return 32'h100;
         2'd1:    return 32'h200;
         2'd2:    return 32'h300;
         default: return 32'h103;
      endcase
   endfunction

   function automatic logic [31:0] addr_of(input logic [4:0] s, input logic [7:0] t);
      return (32'(t) << 11) | (32'(s) << 6);
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge with the response in place
   task automatic issue(input logic [31:0] pc, input logic [31:0] addr);
      req_valid = 1'b1;
      req_pc    = pc;
      req_addr  = addr;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      if (!done) begin
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rsp_valid == 1'b0, "R1", 32'(rsp_valid), 0);
      chk(req_ready == 1'b0, "R1", 32'(req_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", 32'(req_ready), 1);
      chk(rsp_valid == 1'b0, "R2", 32'(rsp_valid), 0);

      for (int i = 0; i < NV; i++) begin
         vec_t  v;
         string rq;
         v  = VECS[i];
         rq = $sformatf("R%0d v%0d", v.rq, i);
         issue(pc_of(v.pcs), addr_of(v.set, v.tag));
         chk(rsp_valid == 1'b1, "R2", 32'(rsp_valid), 1);
         chk(rsp_hit == v.hit, rq, 32'(rsp_hit), 32'(v.hit));
         chk(rsp_bypass == v.byp, rq, 32'(rsp_bypass), 32'(v.byp));
         chk(rsp_evict == v.ev, rq, 32'(rsp_evict), 32'(v.ev));
         if (v.ev)
            chk(rsp_evict_addr == addr_of(v.set, v.evtag), "R5 addr",
                rsp_evict_addr, addr_of(v.set, v.evtag));
      end

      // R2: idle cycle gives no response
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2 idle", 32'(rsp_valid), 0);

      // R1: reset mid-run clears lines and counters
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", 32'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", 32'(req_ready), 1);
      issue(32'h100, addr_of(5'd0, 8'd9));
      chk(rsp_hit == 1'b0, "R1 lines cleared", 32'(rsp_hit), 0);
      chk(rsp_bypass == 1'b0, "R1 counters cleared", 32'(rsp_bypass), 0);
      chk(rsp_evict == 1'b0, "R1 no victim", 32'(rsp_evict), 0);
      issue(32'h100, addr_of(5'd2, 8'd1));
      chk(rsp_bypass == 1'b0, "R1 counters cleared", 32'(rsp_bypass), 0);
      // R3: the line just filled is now present
      issue(32'h200, addr_of(5'd0, 8'd9));
      chk(rsp_hit == 1'b1, "R3", 32'(rsp_hit), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule